// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor

This block is the digital protection supervisor of a synchronous buck controller. It reads comparator flags from the analog front end: output over-voltage, output under-voltage, discharge complete, two current-sense levels and a pre-enable over-voltage level. It also reads the switching-cycle tick, the enable input, two supply-ready flags and the soft-start indication. From these it drives two gate overrides to the gate-driver stage. One forces both gates off. The other forces the low-side switch on to discharge the output.

All faults are sticky. Once a fault is recorded the converter stays off until a supply-ready flag drops or enable is taken low. The supervisor detects faults only while it is armed, meaning enable and both supplies are present. While enable is low, a separate non-latching path turns the low-side switch on whenever the pre-enable over-voltage flag is high. That path protects the load before the converter starts.

Top module: `fsup_ctrl`

## Requirements
- R1: After a synchronous active-low reset, with enable and the pre-enable flag low, every output is 0.
- R2: While armed, when the low current flag is high at OC_CYCLES consecutive cycle ticks, fault_kind bit 0 and fault_latched are 1 from the next clock onward, and force_gates_low is 1.
- R3: A tick with the low current flag low restarts the consecutive-tick count. Cycles without a tick leave the count unchanged.
- R4: While armed, the high current flag sets fault_kind bit 1 on the next clock, with no tick needed.
- R5: While armed, the over-voltage flag held high for OV_FILT consecutive clocks sets fault_kind bit 3 and force_low_side_on on the next clock. A single low cycle restarts the filter.
- R6: When the discharge-complete flag is seen high during discharge, force_low_side_on drops on the next clock. fault_kind bit 3 stays set and force_gates_low becomes 1.
- R7: While armed, the under-voltage flag sets fault_kind bit 2 on the next clock, except in cycles where soft_start is high.
- R8: force_gates_low is 1 exactly when a fault is recorded and force_low_side_on is 0. An over-voltage discharge therefore overrides any force-off request.
- R9: In any clock where enable or either supply flag is low, all recorded faults, counts and the discharge state are cleared at that clock edge.
- R10: While enable is low, force_low_side_on follows pre_ov_flag in the same cycle and records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable |
| supply_a_ok | input | 1 | First supply above its ready level |
| supply_b_ok | input | 1 | Second supply above its ready level |
| soft_start | input | 1 | Soft-start ramp in progress |
| cycle_tick | input | 1 | One-clock pulse per switching cycle |
| oc_low_flag | input | 1 | Current sense above the lower level |
| oc_high_flag | input | 1 | Current sense above the upper level |
| ov_flag | input | 1 | Output above 125 percent of reference |
| uv_flag | input | 1 | Output below 75 percent of reference |
| dis_done_flag | input | 1 | Output below the discharge end level |
| pre_ov_flag | input | 1 | Output above the pre-enable limit |
| force_gates_low | output | 1 | Hold both gates off |
| force_low_side_on | output | 1 | Hold the low-side gate on |
| fault_latched | output | 1 | Any fault recorded |
| fault_kind | output | 4 | Recorded faults: bit0 slow current, bit1 fast current, bit2 under-voltage, bit3 over-voltage |

## Verification
The critical overlap occurs when the over-voltage filter completes in the same clock as a fast over-current or under-voltage trip. The bench provokes this by raising the high current flag on the final filter cycle. It then expects both fault bits set, the low-side override on and the force-off output held low until discharge completes. A second overlap occurs when enable falls while faults are still recorded and the pre-enable flag is high. In that cycle the pre-enable path must win, and the status must clear on the next clock. A cycle-accurate model in the bench judges both cases, together with long random runs.

// File: rtl/fsup_pkg.sv
// Shared definitions for the regulator fault supervisor.
// Assumes nothing beyond a single clock domain.
package fsup_pkg;
    localparam int FK_OC_SLOW = 0;
    localparam int FK_OC_FAST = 1;
    localparam int FK_UV      = 2;
    localparam int FK_OV      = 3;
    localparam int FK_W       = 4;
    typedef logic [FK_W-1:0] fkind_t;
endpackage

// File: rtl/fsup_oc_tier.sv
// Two-tier over-current detector. The slow tier counts consecutive
// switching-cycle ticks seen with the low flag high. The fast tier records
// at once. Both latches clear while the supervisor is not armed.
// Assumes cycle_tick is a single-clock pulse and flags are synchronous.
module fsup_oc_tier #(
    parameter int OC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic tick,
    input  logic oc_lo,
    input  logic oc_hi,
    output logic slow_lat,
    output logic fast_lat
);
    localparam int CW = $clog2(OC_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(OC_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Consecutive-tick counter and both sticky trip latches.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            cnt      <= '0;
            slow_lat <= 1'b0;
            fast_lat <= 1'b0;
        end else begin
            if (tick) begin
                if (oc_lo) begin
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        slow_lat <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end else begin
                    cnt <= '0;
                end
            end
            if (oc_hi) fast_lat <= 1'b1;
        end
    end

    a_r2_slow_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && oc_lo && cnt == LAST) |=> slow_lat);
    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !tick) |=> $stable(cnt));
    a_r4_fast_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && oc_hi) |=> fast_lat);
endmodule

// File: rtl/fsup_ov_guard.sv
// Over-voltage guard. A flag held high for OV_FILT consecutive clocks
// records the fault and starts a low-side discharge. The discharge stops
// once the discharge-complete flag is seen, and the fault stays recorded.
// Assumes the flags are synchronous to clk.
module fsup_ov_guard #(
    parameter int OV_FILT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic ov_in,
    input  logic dis_end,
    output logic ov_lat,
    output logic dis_on
);
    localparam int FW = $clog2(OV_FILT + 1);
    localparam logic [FW-1:0] FLAST = FW'(OV_FILT - 1);

    logic [FW-1:0] fcnt;
    logic          trip;

    // A trip happens on the last consecutive high cycle before latching.
    always_comb trip = !ov_lat && ov_in && (fcnt == FLAST);

    // Filter counter, fault latch and discharge state.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            fcnt   <= '0;
            ov_lat <= 1'b0;
            dis_on <= 1'b0;
        end else begin
            if (trip) begin
                fcnt   <= '0;
                ov_lat <= 1'b1;
                dis_on <= 1'b1;
            end else begin
                if (!ov_lat && ov_in) fcnt <= fcnt + FW'(1);
                else                  fcnt <= '0;
                if (dis_end) dis_on <= 1'b0;
            end
        end
    end

    a_r5_ov_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ov_lat && ov_in && fcnt == FLAST) |=> (ov_lat && dis_on));
    a_r6_dis_end: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ov_lat && dis_on && dis_end) |=> (!dis_on && ov_lat));
endmodule

// File: rtl/fsup_gate_arb.sv
// Gate override arbiter. The low-side discharge, whether from an armed
// over-voltage or from the disabled-state pre-enable path, wins over the
// force-off request. Purely combinational.
module fsup_gate_arb
    import fsup_pkg::*;
(
    input  logic   armed,
    input  logic   en,
    input  logic   pre_ov,
    input  logic   dis_on,
    input  fkind_t fk,
    output logic   gates_low,
    output logic   low_on,
    output logic   any_fault
);
    // Resolve the two override commands and the summary status.
    always_comb begin
        low_on    = (armed && dis_on) || (!en && pre_ov);
        any_fault = |fk;
        gates_low = any_fault && !low_on;
    end
endmodule

// File: rtl/fsup_ctrl.sv
// Regulator fault supervisor top. Arms when enable and both supplies are
// present and clears every record when any of them is absent. Hosts the
// under-voltage latch, which is blanked during soft-start.
// Assumes all inputs are synchronous to clk.
module fsup_ctrl
    import fsup_pkg::*;
#(
    parameter int OC_CYCLES = 4,
    parameter int OV_FILT   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             supply_a_ok,
    input  logic             supply_b_ok,
    input  logic             soft_start,
    input  logic             cycle_tick,
    input  logic             oc_low_flag,
    input  logic             oc_high_flag,
    input  logic             ov_flag,
    input  logic             uv_flag,
    input  logic             dis_done_flag,
    input  logic             pre_ov_flag,
    output logic             force_gates_low,
    output logic             force_low_side_on,
    output logic             fault_latched,
    output logic [FK_W-1:0]  fault_kind
);
    logic   armed;
    logic   slow_lat, fast_lat, ov_lat, dis_on, uv_lat;
    fkind_t fk;

    // Armed only with enable and both supplies present.
    always_comb armed = en && supply_a_ok && supply_b_ok;

    // Under-voltage latch, ignored during soft-start.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)               uv_lat <= 1'b0;
        else if (uv_flag && !soft_start)    uv_lat <= 1'b1;
    end

    // Assemble the fault record in its fixed bit order.
    always_comb begin
        fk             = '0;
        fk[FK_OC_SLOW] = slow_lat;
        fk[FK_OC_FAST] = fast_lat;
        fk[FK_UV]      = uv_lat;
        fk[FK_OV]      = ov_lat;
    end

    fsup_oc_tier #(.OC_CYCLES(OC_CYCLES)) u_oc (
        .clk(clk), .rst_n(rst_n), .armed(armed), .tick(cycle_tick),
        .oc_lo(oc_low_flag), .oc_hi(oc_high_flag),
        .slow_lat(slow_lat), .fast_lat(fast_lat)
    );

    fsup_ov_guard #(.OV_FILT(OV_FILT)) u_ov (
        .clk(clk), .rst_n(rst_n), .armed(armed), .ov_in(ov_flag),
        .dis_end(dis_done_flag), .ov_lat(ov_lat), .dis_on(dis_on)
    );

    fsup_gate_arb u_arb (
        .armed(armed), .en(en), .pre_ov(pre_ov_flag), .dis_on(dis_on), .fk(fk),
        .gates_low(force_gates_low), .low_on(force_low_side_on),
        .any_fault(fault_latched)
    );

    assign fault_kind = fk;

    a_r7_uv_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && uv_flag && !soft_start) |=> fault_kind[FK_UV]);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (fault_kind == '0));
    a_r8_discharge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dis_on) |-> (force_low_side_on && !force_gates_low));
    a_r10_pre_ov: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (force_low_side_on == pre_ov_flag));
endmodule

// File: tb/fsup_ctrl_test.sv
module fsup_ctrl_test;
    localparam int OCN = 4;
    localparam int OVF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, sa = 0, sb = 0, ss = 0, tick = 0, ocl = 0, och = 0;
    logic ov = 0, uv = 0, dend = 0, pre = 0;
    logic gl, lon, fl;
    logic [3:0] fk;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    // bench model state
    int m_oc = 0, m_ov = 0;
    logic [3:0] m_k = '0;
    logic m_dis = 0;

    always #4 clk = ~clk;

    fsup_ctrl #(.OC_CYCLES(OCN), .OV_FILT(OVF)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .supply_a_ok(sa), .supply_b_ok(sb),
        .soft_start(ss), .cycle_tick(tick), .oc_low_flag(ocl), .oc_high_flag(och),
        .ov_flag(ov), .uv_flag(uv), .dis_done_flag(dend), .pre_ov_flag(pre),
        .force_gates_low(gl), .force_low_side_on(lon), .fault_latched(fl),
        .fault_kind(fk)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [6:0] expected_out();
        logic armed, lo, anyf;
        armed = en && sa && sb;
        lo    = (armed && m_dis) || (!en && pre);
        anyf  = |m_k;
        return {anyf && !lo, lo, anyf, m_k};
    endfunction

    task automatic model_update();
        logic armed, trip;
        armed = en && sa && sb;
        if (!rst_n || !armed) begin
            m_oc = 0; m_ov = 0; m_k = '0; m_dis = 0;
        end else begin
            if (tick) begin
                if (ocl) begin
                    if (m_oc == OCN - 1) begin m_oc = 0; m_k[0] = 1; end
                    else m_oc++;
                end else m_oc = 0;
            end
            if (och) m_k[1] = 1;
            if (uv && !ss) m_k[2] = 1;
            trip = !m_k[3] && ov && (m_ov == OVF - 1);
            if (trip) begin
                m_ov = 0; m_k[3] = 1; m_dis = 1;
            end else begin
                if (!m_k[3] && ov) m_ov++; else m_ov = 0;
                if (dend) m_dis = 0;
            end
        end
    endtask

    // Compare outputs mid-cycle, advance the model, move to the next negedge.
    task automatic step(input string tag);
        logic [6:0] e, a;
        #1;
        e = expected_out();
        a = {gl, lon, fl, fk};
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s: {gl,lon,fl,kind} actual=%b expected=%b", tag, a, e);
        end
        model_update();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet_arm();
        en = 1; sa = 1; sb = 1; ss = 0; tick = 0; ocl = 0; och = 0;
        ov = 0; uv = 0; dend = 0; pre = 0;
    endtask

    task automatic disarm_clear(input string tag);
        en = 0; pre = 0;
        step(tag);
        quiet_arm();
        step(tag);
    endtask

    logic [31:0] seed_v;

    initial begin
        seed_v = $urandom(32'h1D5EED);
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R1 reset state");
        step("R1 reset state");

        // R2: four consecutive ticks with low current flag
        quiet_arm();
        step("R2 armed idle");
        ocl = 1;
        for (int i = 0; i < 3 * OCN + 2; i++) begin
            tick = (i % 3 == 0);
            step("R2 slow current count");
        end
        tick = 0; ocl = 0;
        step("R2 slow current latched");
        disarm_clear("R9 clear after slow trip");

        // R3: a clean tick restarts the count
        for (int i = 0; i < OCN - 1; i++) begin
            ocl = 1; tick = 1; step("R3 partial count");
            tick = 0; step("R3 no tick hold");
        end
        ocl = 0; tick = 1; step("R3 clean tick restart");
        ocl = 1;
        for (int i = 0; i < OCN - 1; i++) begin
            tick = 1; step("R3 recount no trip");
            tick = 0; step("R3 recount no trip");
        end
        tick = 1; step("R3 final tick trips");
        tick = 0; step("R3 trip visible");
        ocl = 0;
        disarm_clear("R9 clear after recount");

        // R4: fast current trip, one cycle
        och = 1; step("R4 fast current");
        och = 0; step("R4 fast current latched");
        step("R4 fast current sticky");
        sb = 0; step("R9 supply drop clears");
        sb = 1; step("R9 cleared");

        // R5: filter gap then full filter
        ov = 1;
        for (int i = 0; i < OVF - 1; i++) step("R5 filter short");
        ov = 0; step("R5 filter gap");
        ov = 1;
        for (int i = 0; i < OVF; i++) step("R5 filter full");
        step("R5 discharge on");
        ov = 0;
        // R6: discharge ends
        step("R6 discharging");
        dend = 1; step("R6 discharge end seen");
        dend = 0; step("R6 latched off");
        step("R6 latched off");
        disarm_clear("R9 clear after ov");

        // R7: under-voltage blanked by soft-start
        ss = 1; uv = 1;
        for (int i = 0; i < 4; i++) step("R7 uv blanked");
        ss = 0; step("R7 uv trip");
        uv = 0; step("R7 uv latched");
        disarm_clear("R9 clear after uv");

        // R8: ov trip coincides with fast current trip
        ov = 1;
        for (int i = 0; i < OVF - 1; i++) step("R8 filter");
        och = 1; step("R8 coincident trip");
        och = 0; ov = 0; step("R8 discharge wins");
        step("R8 discharge wins");
        dend = 1; step("R8 discharge end");
        dend = 0; step("R8 force low after discharge");

        // R10: enable falls with faults recorded, pre flag high
        en = 0; pre = 1; step("R10 pre path wins at disable");
        step("R10 pre path no latch");
        pre = 0; step("R10 pre released");
        pre = 1; step("R10 pre again");
        ov = 1; uv = 1; och = 1;
        for (int i = 0; i < OVF + 2; i++) step("R10 disabled ignores faults");
        ov = 0; uv = 0; och = 0; pre = 0;
        step("R10 disabled idle");

        // Random phase
        quiet_arm();
        for (int i = 0; i < 4000; i++) begin
            en   = ($urandom % 50) != 0;
            sa   = ($urandom % 200) != 0;
            sb   = ($urandom % 200) != 0;
            ss   = ($urandom % 2) == 0;
            tick = ($urandom % 4) == 0;
            ocl  = ($urandom % 3) != 0;
            och  = ($urandom % 300) == 0;
            uv   = ($urandom % 200) == 0;
            ov   = ov ? (($urandom % 10) != 0) : (($urandom % 60) == 0);
            dend = ($urandom % 20) == 0;
            pre  = ($urandom % 2) == 0;
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule